// File: doc/BRIEF.md
# Graphics aperture address translator

The block maps addresses that land inside a programmable graphics aperture onto 40-bit physical addresses. The aperture is a window aligned to 32 MB. Its size is a power of two chosen by a 3-bit code. Every 4 KB page of the window has one 32-bit entry in a translation table in memory. The block fetches that entry, checks it and builds the physical address from it. A four-entry, fully associative cache holds recently used entries, so repeated accesses to a page need no memory read.

Software sets the block up through four registers on a simple write-strobe/read-data bus. The registers hold the aperture control, the aperture base, the table base and a cache control word. The cache control word invalidates the cache and keeps a sticky flag for bad table entries. Each request carries an address and a source flag (CPU or IO). Requests outside the window, or from a source whose translation is switched off, pass through unchanged and are marked as bypassed.

Top module: `apx_xlate`

## Requirements
- R1: After reset, all four registers read 0, `rsp_valid` and `mem_rd_valid` are 0, and `req_ready` is 1.
- R2: Registers are decoded at offsets 0x90 (control), 0x94 (base), 0x98 (table base) and 0x9C (cache control). Control keeps bits 6:0: bit 0 enable, bits 3:1 size code, bit 4 CPU disable, bit 5 IO disable, bit 6 stored only. Base keeps bits 14:0. Table base keeps bits 31:4, and bits 3:0 read 0. Any other offset reads 0.
- R3: The window starts at base bits 6:0 placed at address bits 31:25. Its size is 32 MB << code for codes 0 to 6, and code 7 gives an empty window. A request with enable set and an address in [start, start+size) is translated. Any other request returns the zero-extended request address with `rsp_bypass`=1 and `rsp_fault`=0.
- R4: `req_is_io`=0 marks a CPU request. Control bit 4 makes CPU requests bypass, and bit 5 makes IO requests bypass.
- R5: On a cache miss, `mem_rd_addr` = (table base bits 31:4 followed by twelve zero bits) + 4*((address - start) >> 12). The address stays stable with `mem_rd_valid`=1 until `mem_rd_ack`.
- R6: An entry whose bits 1:0 equal 3 gives physical address = {entry[11:4], entry[31:12], request[11:0]}.
- R7: An entry whose bits 1:0 are not 3 gives `rsp_fault`=1 and `rsp_addr`=0. It sets cache-control bit 1 and is not cached, so a repeated access reads memory again.
- R8: A page that is already cached gets its response one cycle after acceptance, with no memory read.
- R9: The cache holds 4 pages and replaces them in round-robin order over successful fills. After five distinct pages are filled, the first one misses and the newer ones hit.
- R10: Writing 1 to cache-control bit 0 makes that bit read 1 in the next cycle and 0 after that. `req_ready` is low while the bit reads 1, and every cached page is dropped.
- R11: Writing 1 to cache-control bit 1 clears the error flag. Writing 0 to it leaves the flag as it is.
- R12: Each accepted request produces exactly one `rsp_valid` pulse. It comes one cycle after acceptance for hits and bypasses, and one cycle after `mem_rd_ack` for misses. `req_ready` is low while a fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | 32 | Request address |
| req_is_io | input | 1 | 1 = IO source, 0 = CPU source |
| mem_rd_valid | output | 1 | Table-entry read outstanding |
| mem_rd_addr | output | 40 | Physical address of the table entry |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Table entry |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 40 | Translated or passed-through address |
| rsp_bypass | output | 1 | Request was not translated |
| rsp_fault | output | 1 | Table entry was unusable |

## Verification
The vector walk mixes first touches, repeats within one page, addresses just below the window start and exactly at its end, and a faulting page touched twice. These cases tell a cached hit from a fresh fetch, and they show whether faulting entries leak into the cache. A run of five distinct pages followed by revisits separates round-robin replacement from any other victim choice. Directed cases vary the source flag against each disable bit, the largest size code against the empty code 7, and the invalidate bit before and after a page is cached. They show that the window limits, the source gating and the flush each act on their own.

// File: rtl/apx_pkg.sv
`timescale 1ns/1ps
package apx_pkg;
    localparam int ADDR_W  = 32;
    localparam int PAGE_W  = 12;
    localparam int VPN_W   = ADDR_W - PAGE_W;
    localparam int WIN_LSB = 25;
    localparam int WIN_W   = ADDR_W - WIN_LSB;
    localparam int TBL_LSB = 4;
    localparam int TBL_SH  = 8;
    localparam int PA_W    = ADDR_W + TBL_SH;
    localparam int PPN_W   = PA_W - PAGE_W;
    localparam int REG_AW  = 8;
    localparam int CTRL_W  = 7;
    localparam int BASE_W  = 15;

    localparam logic [REG_AW-1:0] OFF_CTRL = 8'h90;
    localparam logic [REG_AW-1:0] OFF_BASE = 8'h94;
    localparam logic [REG_AW-1:0] OFF_TBL  = 8'h98;
    localparam logic [REG_AW-1:0] OFF_CC   = 8'h9C;

    typedef enum logic [0:0] {ST_IDLE, ST_FETCH} apx_state_e;

    typedef struct packed {
        logic                   en;
        logic [2:0]             size_code;
        logic                   dis_cpu;
        logic                   dis_io;
        logic [WIN_W-1:0]       win_base;
        logic [ADDR_W-1:TBL_LSB] tbl_base;
    } apx_cfg_t;
endpackage

// File: rtl/apx_regs.sv
`timescale 1ns/1ps
module apx_regs
    import apx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [ADDR_W-1:0] wdata,
    input  logic              err_set,
    input  logic              inv_take,
    output logic [ADDR_W-1:0] rdata,
    output apx_cfg_t          cfg,
    output logic              inv_pend
);
    typedef struct packed {
        logic [CTRL_W-1:0]        ctrl;
        logic [BASE_W-1:0]        base;
        logic [ADDR_W-1:TBL_LSB]  tbl;
        logic                     err;
        logic                     inv;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (inv_take) d.inv = 1'b0;
        if (wr_en) begin
            case (addr)
                OFF_CTRL: d.ctrl = wdata[CTRL_W-1:0];
                OFF_BASE: d.base = wdata[BASE_W-1:0];
                OFF_TBL:  d.tbl  = wdata[ADDR_W-1:TBL_LSB];
                OFF_CC: begin
                    if (wdata[0]) d.inv = 1'b1;
                    if (wdata[1]) d.err = 1'b0;
                end
                default: ;
            endcase
        end
        if (err_set) d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (addr)
            OFF_CTRL: rdata = ADDR_W'(q.ctrl);
            OFF_BASE: rdata = ADDR_W'(q.base);
            OFF_TBL:  rdata = {q.tbl, {TBL_LSB{1'b0}}};
            OFF_CC:   rdata = ADDR_W'({q.err, q.inv});
            default:  rdata = '0;
        endcase
    end

    assign cfg.en        = q.ctrl[0];
    assign cfg.size_code = q.ctrl[3:1];
    assign cfg.dis_cpu   = q.ctrl[4];
    assign cfg.dis_io    = q.ctrl[5];
    assign cfg.win_base  = q.base[WIN_W-1:0];
    assign cfg.tbl_base  = q.tbl;
    assign inv_pend      = q.inv;

    a_r10_inv_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CC && wdata[0]) |=> q.inv)
        else $error("R10 invalidate bit not set after write");

    a_r11_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CC && wdata[1] && !err_set) |=> !q.err)
        else $error("R11 error flag not cleared");
endmodule

// File: rtl/apx_window.sv
`timescale 1ns/1ps
module apx_window
    import apx_pkg::*;
(
    input  logic             en,
    input  logic [2:0]       size_code,
    input  logic             dis_cpu,
    input  logic             dis_io,
    input  logic [WIN_W-1:0] win_base,
    input  logic [VPN_W-1:0] vpn,
    input  logic             is_io,
    output logic             xlate,
    output logic [VPN_W-1:0] idx
);
    localparam int SUB_W = WIN_LSB - PAGE_W;

    logic             in_lo, size_ok, src_ok;
    logic [VPN_W-1:0] off;

    always_comb begin
        off     = vpn - {win_base, {SUB_W{1'b0}}};
        in_lo   = vpn[VPN_W-1:SUB_W] >= win_base;
        size_ok = (size_code != 3'd7) &&
                  (off[VPN_W-1:SUB_W] < (WIN_W'(1) << size_code));
        src_ok  = is_io ? !dis_io : !dis_cpu;
        xlate   = en && src_ok && in_lo && size_ok;
        idx     = off;
    end
endmodule

// File: rtl/apx_tlb.sv
`timescale 1ns/1ps
module apx_tlb #(
    parameter int N     = 4,
    parameter int TAG_W = 20,
    parameter int DAT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [DAT_W-1:0] hit_dat,
    input  logic             fill,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [DAT_W-1:0] fill_dat,
    input  logic             flush
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]             vld;
        logic [N-1:0][TAG_W-1:0]  tag;
        logic [N-1:0][DAT_W-1:0]  dat;
        logic [PTR_W-1:0]         ptr;
    } tlb_t;

    tlb_t       q, d;
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_match
        assign hit_vec[g] = q.vld[g] && (q.tag[g] == lk_tag);
    end

    always_comb begin
        hit_dat = '0;
        for (int i = 0; i < N; i++)
            if (hit_vec[i]) hit_dat = hit_dat | q.dat[i];
        hit = |hit_vec;
    end

    always_comb begin
        d = q;
        if (flush) begin
            d.vld = '0;
        end else if (fill) begin
            d.vld[q.ptr] = 1'b1;
            d.tag[q.ptr] = fill_tag;
            d.dat[q.ptr] = fill_dat;
            d.ptr = (q.ptr == PTR_W'(N-1)) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec))
        else $error("R9 page cached in more than one slot");

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (q.vld == '0))
        else $error("R10 entries survive invalidate");
endmodule

// File: rtl/apx_xlate.sv
`timescale 1ns/1ps
module apx_xlate
    import apx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_is_io,
    output logic              mem_rd_valid,
    output logic [PA_W-1:0]   mem_rd_addr,
    input  logic              mem_rd_ack,
    input  logic [ADDR_W-1:0] mem_rd_data,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_addr,
    output logic              rsp_bypass,
    output logic              rsp_fault
);
    localparam int TBL_PAD = PA_W - ADDR_W + TBL_LSB;

    typedef struct packed {
        apx_state_e         state;
        logic [VPN_W-1:0]   vpn;
        logic [PAGE_W-1:0]  pofs;
        logic [PA_W-1:0]    maddr;
        logic               rv;
        logic [PA_W-1:0]    raddr;
        logic               rbyp;
        logic               rflt;
    } top_t;

    top_t q, d;

    apx_cfg_t         cfg;
    logic             inv_pend, inv_take, err_set;
    logic             xlate, hit, fill, accept, usable;
    logic [VPN_W-1:0] idx;
    logic [PPN_W-1:0] hit_ppn, ent_ppn;
    logic             unused_ent_bits;

    apx_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .err_set  (err_set),
        .inv_take (inv_take),
        .rdata    (reg_rdata),
        .cfg      (cfg),
        .inv_pend (inv_pend)
    );

    apx_window u_win (
        .en        (cfg.en),
        .size_code (cfg.size_code),
        .dis_cpu   (cfg.dis_cpu),
        .dis_io    (cfg.dis_io),
        .win_base  (cfg.win_base),
        .vpn       (req_addr[ADDR_W-1:PAGE_W]),
        .is_io     (req_is_io),
        .xlate     (xlate),
        .idx       (idx)
    );

    apx_tlb #(.N(4), .TAG_W(VPN_W), .DAT_W(PPN_W)) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (req_addr[ADDR_W-1:PAGE_W]),
        .hit      (hit),
        .hit_dat  (hit_ppn),
        .fill     (fill),
        .fill_tag (q.vpn),
        .fill_dat (ent_ppn),
        .flush    (inv_take)
    );

    assign ent_ppn         = {mem_rd_data[11:4], mem_rd_data[31:12]};
    assign usable          = (mem_rd_data[1:0] == 2'b11);
    assign unused_ent_bits = ^mem_rd_data[3:2];

    assign req_ready = (q.state == ST_IDLE) && !inv_pend;
    assign accept    = req_valid && req_ready;
    assign inv_take  = inv_pend && (q.state == ST_IDLE);

    always_comb begin
        d       = q;
        d.rv    = 1'b0;
        fill    = 1'b0;
        err_set = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    if (!xlate) begin
                        d.rv    = 1'b1;
                        d.raddr = PA_W'(req_addr);
                        d.rbyp  = 1'b1;
                        d.rflt  = 1'b0;
                    end else if (hit) begin
                        d.rv    = 1'b1;
                        d.raddr = {hit_ppn, req_addr[PAGE_W-1:0]};
                        d.rbyp  = 1'b0;
                        d.rflt  = 1'b0;
                    end else begin
                        d.state = ST_FETCH;
                        d.vpn   = req_addr[ADDR_W-1:PAGE_W];
                        d.pofs  = req_addr[PAGE_W-1:0];
                        d.maddr = {cfg.tbl_base, {TBL_PAD{1'b0}}} +
                                  PA_W'({idx, 2'b00});
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_ack) begin
                    d.state = ST_IDLE;
                    d.rv    = 1'b1;
                    d.rbyp  = 1'b0;
                    if (usable) begin
                        d.raddr = {ent_ppn, q.pofs};
                        d.rflt  = 1'b0;
                        fill    = 1'b1;
                    end else begin
                        d.raddr = '0;
                        d.rflt  = 1'b1;
                        err_set = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_rd_valid = (q.state == ST_FETCH);
    assign mem_rd_addr  = q.maddr;
    assign rsp_valid    = q.rv;
    assign rsp_addr     = q.raddr;
    assign rsp_bypass   = q.rbyp;
    assign rsp_fault    = q.rflt;

    a_r5_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ack) |=> (mem_rd_valid && $stable(mem_rd_addr)))
        else $error("R5 table read dropped or changed before ack");

    a_r7_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (!rsp_bypass && rsp_addr == '0))
        else $error("R7 fault response carries data");

    a_r12_rsp_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid && req_ready) || $past(mem_rd_valid && mem_rd_ack)))
        else $error("R12 response without cause");

    a_r3_code7_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg.size_code == 3'd7) |=> (rsp_valid && rsp_bypass))
        else $error("R3 code 7 window not empty");
endmodule

// File: tb/apx_xlate_tb_top.sv
`timescale 1ns/1ps
module apx_xlate_tb_top;
    localparam logic [39:0] TBL     = 40'h0012345000;
    localparam logic [31:0] TBL_REG = 32'h00123450;
    localparam int K_BYP = 0, K_MISS = 1, K_HIT = 2, K_FLT = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic        io;
        logic [1:0]  kind;
        logic [1:0]  dly;
    } vec_t;

    // R9: pages 0..4 fill slots 0,1,2,3,0; page 0 then returns as a miss
    localparam vec_t VECS [14] = '{
        '{32'h10000000, 1'b0, 2'd1, 2'd0},
        '{32'h10000ABC, 1'b0, 2'd2, 2'd0},
        '{32'h10001004, 1'b1, 2'd1, 2'd2},
        '{32'h0FFFFFFF, 1'b0, 2'd0, 2'd0},
        '{32'h14000000, 1'b0, 2'd0, 2'd0},
        '{32'h13FFFFFC, 1'b0, 2'd3, 2'd0},
        '{32'h13FFF010, 1'b1, 2'd3, 2'd1},
        '{32'h10002000, 1'b0, 2'd1, 2'd0},
        '{32'h10003000, 1'b0, 2'd1, 2'd0},
        '{32'h10004000, 1'b0, 2'd1, 2'd0},
        '{32'h10001FFF, 1'b0, 2'd2, 2'd0},
        '{32'h10000000, 1'b0, 2'd1, 2'd0},
        '{32'h10002010, 1'b0, 2'd2, 2'd0},
        '{32'h10001000, 1'b0, 2'd1, 2'd0}
    };

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        req_valid = 1'b0, req_ready, req_is_io = 1'b0;
    logic [31:0] req_addr = '0;
    logic        mem_rd_valid, mem_rd_ack = 1'b0;
    logic [39:0] mem_rd_addr, rsp_addr;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid, rsp_bypass, rsp_fault;

    int n_chk = 0, n_fail = 0;
    logic [31:0] cur_start = 32'h10000000;

    always #10 clk = ~clk;

    apx_xlate dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_is_io(req_is_io),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_bypass(rsp_bypass), .rsp_fault(rsp_fault)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] ent(input logic [19:0] idx);
        logic [31:0] e;
        e[31:12] = idx ^ 20'hC3A50;
        e[11:4]  = idx[7:0] + 8'h11;
        e[3:2]   = 2'b00;
        e[1:0]   = (idx[3:0] == 4'hF) ? 2'b01 : 2'b11;
        return e;
    endfunction

    function automatic logic [31:0] mem_model(input logic [39:0] a);
        logic [39:0] off;
        off = (a - TBL) >> 2;
        return ent(off[19:0]);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_now(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic issue(input logic [31:0] a, input logic io, input int dly,
                         output logic saw, output logic [39:0] ra,
                         output logic [39:0] raddr, output logic rb,
                         output logic rf, output int lat);
        @(negedge clk);
        req_addr = a; req_is_io = io; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; saw = 1'b0; ra = '0;
        while (!rsp_valid && lat < 40) begin
            if (mem_rd_valid && !saw) begin
                saw = 1'b1;
                ra  = mem_rd_addr;
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    lat++;
                end
                mem_rd_data = mem_model(ra);
                mem_rd_ack  = 1'b1;
                @(negedge clk);
                mem_rd_ack  = 1'b0;
                lat++;
            end else begin
                @(negedge clk);
                lat++;
            end
        end
        raddr = rsp_addr; rb = rsp_bypass; rf = rsp_fault;
    endtask

    task automatic run_chk(input string tg, input logic [31:0] a, input logic io,
                           input int kind, input int dly);
        logic        saw, rb, rf;
        logic [39:0] ra, raddr, exp_addr;
        logic [31:0] off, e;
        logic [19:0] idx;
        int          lat;
        logic        miss;
        issue(a, io, dly, saw, ra, raddr, rb, rf, lat);
        miss = (kind == K_MISS || kind == K_FLT);
        off  = a - cur_start;
        idx  = off[31:12];
        e    = ent(idx);
        check($sformatf("R12 latency %s addr %h", tg, a), 64'(lat), miss ? 64'(2 + dly) : 64'd1);
        check($sformatf("%s table read issued for %h", tg, a), 64'(saw), 64'(miss));
        if (miss)
            check($sformatf("R5 entry address for %h", a), 64'(ra), 64'(TBL + {idx, 2'b00}));
        case (kind)
            K_BYP:   exp_addr = {8'h00, a};
            K_FLT:   exp_addr = '0;
            default: exp_addr = {e[11:4], e[31:12], a[11:0]};
        endcase
        check($sformatf("%s result (R6 layout) for %h", tg, a), 64'(raddr), 64'(exp_addr));
        check($sformatf("%s bypass flag for %h", tg, a), 64'(rb), 64'(kind == K_BYP));
        check($sformatf("%s fault flag for %h", tg, a), 64'(rf), 64'(kind == K_FLT));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        string tg;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        rd_now(8'h90, v); check("R1 control after reset", 64'(v), 64'd0);
        rd_now(8'h94, v); check("R1 base after reset", 64'(v), 64'd0);
        rd_now(8'h98, v); check("R1 table base after reset", 64'(v), 64'd0);
        rd_now(8'h9C, v); check("R1 cache control after reset", 64'(v), 64'd0);
        check("R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);
        check("R1 mem_rd_valid after reset", 64'(mem_rd_valid), 64'd0);
        check("R1 req_ready after reset", 64'(req_ready), 64'd1);

        // R2 field widths and decode
        wr(8'h90, 32'hFFFFFFFF); rd_now(8'h90, v); check("R2 control width", 64'(v), 64'h7F);
        wr(8'h94, 32'hFFFFFFFF); rd_now(8'h94, v); check("R2 base width", 64'(v), 64'h7FFF);
        wr(8'h98, 32'hFFFFFFFF); rd_now(8'h98, v); check("R2 table base low bits", 64'(v), 64'hFFFFFFF0);
        rd_now(8'h80, v); check("R2 unmapped offset", 64'(v), 64'd0);

        wr(8'h90, 32'h00000003);
        wr(8'h94, 32'h00000008);
        wr(8'h98, TBL_REG);

        foreach (VECS[i]) begin
            case (int'(VECS[i].kind))
                K_BYP:   tg = "R3";
                K_MISS:  tg = "R5";
                K_HIT:   tg = "R8";
                default: tg = "R7";
            endcase
            run_chk(tg, VECS[i].addr, VECS[i].io, int'(VECS[i].kind), int'(VECS[i].dly));
        end
        // R9: page 4 is still resident after later fills
        run_chk("R9", 32'h10004000, 1'b0, K_HIT, 0);

        // R7 / R11 sticky error flag
        @(negedge clk);
        rd_now(8'h9C, v); check("R7 error flag set", 64'(v), 64'h2);
        wr(8'h9C, 32'h0); rd_now(8'h9C, v); check("R11 write 0 keeps flag", 64'(v), 64'h2);
        wr(8'h9C, 32'h2); rd_now(8'h9C, v); check("R11 write 1 clears flag", 64'(v), 64'h0);

        // R10 invalidate
        run_chk("R8", 32'h10003000, 1'b0, K_HIT, 0);
        wr(8'h9C, 32'h1);
        rd_now(8'h9C, v); check("R10 invalidate bit reads 1", 64'(v), 64'h1);
        check("R10 ready low while invalidating", 64'(req_ready), 64'd0);
        @(negedge clk);
        rd_now(8'h9C, v); check("R10 invalidate bit self-clears", 64'(v), 64'h0);
        run_chk("R10", 32'h10003000, 1'b0, K_MISS, 0);

        // R4 source gating
        wr(8'h90, 32'h13);
        run_chk("R4", 32'h10003000, 1'b0, K_BYP, 0);
        run_chk("R4", 32'h10003008, 1'b1, K_HIT, 0);
        wr(8'h90, 32'h23);
        run_chk("R4", 32'h10003000, 1'b1, K_BYP, 0);
        run_chk("R4", 32'h10003004, 1'b0, K_HIT, 0);

        // R3 size codes
        wr(8'h90, 32'h0F);
        run_chk("R3", 32'h10000000, 1'b0, K_BYP, 0);
        wr(8'h90, 32'h0D);
        run_chk("R3", 32'h8FFFF000, 1'b0, K_FLT, 0);
        run_chk("R3", 32'h90000000, 1'b0, K_BYP, 0);
        wr(8'h90, 32'h02);
        run_chk("R3", 32'h10003000, 1'b0, K_BYP, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule